// File: doc/BRIEF.md
# Commit-Latched Switch Mode Selector

This block turns two slow, bouncy slide-switch inputs into a stable generator mode. It does not try to filter the switches while they move. The switch bits are copied into the mode register only when a separate push-button is pressed to commit them. At all other times the captured mode holds its value, so neither switch bounce nor a half-set combination of switches can reach the downstream data generator.

All three raw inputs are asynchronous. Each one passes through a multi-stage flip-flop synchronizer clocked by the 100 MHz system clock. A commit is a rising edge of the synchronized button. After each accepted commit, a lockout window (default 1,000,000 cycles, about 10 ms) ignores any further edges, so button bounce cannot start another capture. A commit registers the two-bit mode, a four-bit pattern word decoded from it, and a one-cycle update pulse, all on the same clock edge.

Top module: `swsel_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, mode is 00, pattern is 1110 and the update pulse is low.
- R2: Without a commit, changes on the switch inputs leave mode, pattern and the update pulse unchanged.
- R3: When the raw button rises, the switch value is captured and appears on mode at the third rising clock edge. The switches must have been stable for at least three cycles before that.
- R4: The pattern output always equals the decode of the mode output: 00 gives 1110, 01 gives 0001, 10 gives 0101 and 11 gives 1010.
- R5: The update pulse is high for exactly one clock cycle on each accepted commit, in the same cycle that the new mode first appears.
- R6: Button edges that arrive within LOCKOUT_CYCLES cycles after an accepted commit are ignored, even if the switches have changed meanwhile.
- R7: Once the lockout has run out, a new rising edge of the button is accepted and captures the current switch value.
- R8: Holding the button high gives a single commit, no matter how long it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw | input | 2 | Asynchronous slide-switch bits |
| btn_raw | input | 1 | Asynchronous commit push-button, high when pressed |
| mode | output | 2 | Registered captured mode |
| pattern | output | 4 | Registered pattern word for the generator |
| mode_updated | output | 1 | One-cycle pulse on each accepted commit |

## Verification
The assertions check four behaviours on every cycle:
- pattern always agrees with mode;
- mode never changes without the update pulse;
- the pulse never lasts longer than one cycle;
- no second pulse appears inside the lockout window.

Only the bench scenarios can show the rest: the exact three-edge latency from a raw button edge, the capture of the right switch value when switches move around a press, the silence through a burst of bounce edges, and the single commit for a long hold.

// File: rtl/swsel_pkg.sv
package swsel_pkg;
  localparam int MODE_W = 2;
  localparam int PAT_W  = 4;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [PAT_W-1:0]  pat_t;

  localparam mode_t MODE_RESET = 2'b00;

  function automatic pat_t pattern_of(input mode_t m);
    pat_t p;
    case (m)
      2'b00:   p = 4'b1110;
      2'b01:   p = 4'b0001;
      2'b10:   p = 4'b0101;
      default: p = 4'b1010;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/swsel_sync.sv
module swsel_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/swsel_commit_gate.sv
module swsel_commit_gate #(
  parameter int LOCKOUT_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_sync,
  output logic accept
);
  localparam int CNT_W = $clog2(LOCKOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCKOUT_CYCLES);

  logic             btn_prev;
  logic [CNT_W-1:0] hold_cnt;
  logic             locked;

  assign locked = (hold_cnt != '0);
  assign accept = btn_sync & ~btn_prev & ~locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_prev <= 1'b0;
      hold_cnt <= '0;
    end else begin
      btn_prev <= btn_sync;
      if (accept)      hold_cnt <= CNT_LOAD;
      else if (locked) hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/swsel_top.sv
module swsel_top
  import swsel_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int LOCKOUT_CYCLES = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] sw_raw,
  input  logic              btn_raw,
  output logic [MODE_W-1:0] mode,
  output logic [PAT_W-1:0]  pattern,
  output logic              mode_updated
);
  mode_t sw_sync;
  logic  btn_sync;
  logic  accept;

  mode_t mode_q;
  pat_t  pat_q;
  logic  upd_q;

  swsel_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_sw_sync (
    .clk(clk), .rst(rst), .d(sw_raw), .q(sw_sync)
  );

  swsel_sync #(.W(1), .STAGES(SYNC_STAGES)) u_btn_sync (
    .clk(clk), .rst(rst), .d(btn_raw), .q(btn_sync)
  );

  swsel_commit_gate #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_gate (
    .clk(clk), .rst(rst), .btn_sync(btn_sync), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
      pat_q  <= pattern_of(MODE_RESET);
      upd_q  <= 1'b0;
    end else begin
      upd_q <= accept;
      if (accept) begin
        mode_q <= sw_sync;
        pat_q  <= pattern_of(sw_sync);
      end
    end
  end

  assign mode         = mode_q;
  assign pattern      = pat_q;
  assign mode_updated = upd_q;
endmodule

// File: rtl/swsel_checker.sv
module swsel_checker
  import swsel_pkg::*;
#(
  parameter int LOCKOUT_CYCLES = 1_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode,
  input logic [PAT_W-1:0]  pattern,
  input logic              mode_updated
);
  localparam int CW = $clog2(LOCKOUT_CYCLES + 1);

  logic          armed = 1'b0;
  logic          rst_d = 1'b0;
  logic [CW-1:0] win_cnt = '0;

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    rst_d <= rst;
    if (rst)               win_cnt <= '0;
    else if (mode_updated) win_cnt <= CW'(LOCKOUT_CYCLES);
    else if (win_cnt != 0) win_cnt <= win_cnt - 1'b1;
  end

  // R1: outputs at reset values in the cycle after reset
  always_ff @(posedge clk) begin
    if (armed && rst_d)
      assert_reset_state_R1: assert (mode == MODE_RESET && pattern == 4'b1110 && !mode_updated);
  end

  assert_pattern_matches_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    pattern == pattern_of(mode));

  assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(mode) |-> mode_updated);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    mode_updated |=> !mode_updated);

  assert_lockout_window_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    mode_updated |-> win_cnt == '0);
endmodule

bind swsel_top swsel_checker #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .pattern(pattern), .mode_updated(mode_updated)
);

// File: tb/swsel_top_tb.sv
module swsel_top_tb;
  localparam int LOCK = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sw_raw = 2'b00;
  logic       btn_raw = 1'b0;
  logic [1:0] mode;
  logic [3:0] pattern;
  logic       mode_updated;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  // table entries: {switch code, expected pattern}
  localparam logic [5:0] VEC [6] = '{
    {2'b01, 4'b0001}, {2'b11, 4'b1010}, {2'b10, 4'b0101},
    {2'b00, 4'b1110}, {2'b10, 4'b0101}, {2'b01, 4'b0001}
  };

  swsel_top #(.SYNC_STAGES(2), .LOCKOUT_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst(rst), .sw_raw(sw_raw), .btn_raw(btn_raw),
    .mode(mode), .pattern(pattern), .mode_updated(mode_updated)
  );

  always #5 clk = ~clk;

  always @(posedge clk) pulses <= pulses + int'(mode_updated);

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // press with R3 latency and R5 width checks; button released afterwards
  task automatic press_check(input logic [1:0] code, input logic [3:0] pat);
    sw_raw = code;
    tick(5);
    btn_raw = 1'b1;
    tick(); check("R3 no pulse after edge 1", mode_updated, 0);
    tick(); check("R3 no pulse after edge 2", mode_updated, 0);
    tick();
    check("R5 pulse at edge 3", mode_updated, 1);
    check("R3 mode captured", mode, code);
    check("R4 pattern decode", pattern, pat);
    tick(); check("R5 pulse one cycle", mode_updated, 0);
    btn_raw = 1'b0;
  endtask

  initial begin
    int p0;
    tick(3);
    check("R1 reset mode", mode, 0);
    check("R1 reset pattern", pattern, 4'b1110);
    check("R1 reset pulse", mode_updated, 0);
    rst = 1'b0;
    tick(2);
    check("R1 post-reset mode", mode, 0);

    for (int i = 0; i < 6; i++) begin
      press_check(VEC[i][5:4], VEC[i][3:0]);
      tick(LOCK + 10);
    end

    // R2: switches move with no commit
    p0 = pulses;
    for (int k = 0; k < 8; k++) begin
      sw_raw = 2'(k);
      tick(3);
    end
    tick(4);
    check("R2 mode held", mode, 2'b01);
    check("R2 pattern held", pattern, 4'b0001);
    check("R2 no pulse", pulses - p0, 0);

    // R6: bounce during lockout with changed switches
    press_check(2'b10, 4'b0101);
    sw_raw = 2'b11;
    p0 = pulses;
    for (int k = 0; k < 4; k++) begin
      btn_raw = 1'b1; tick(3);
      btn_raw = 1'b0; tick(3);
    end
    tick(2);
    check("R6 bounce no pulse", pulses - p0, 0);
    check("R6 mode held", mode, 2'b10);
    tick(LOCK);

    // R7: accepted after lockout
    press_check(2'b11, 4'b1010);
    tick(LOCK + 10);

    // R8: long hold gives one commit
    sw_raw = 2'b00;
    tick(5);
    p0 = pulses;
    btn_raw = 1'b1;
    tick(4);
    sw_raw = 2'b01;
    tick(4 * LOCK);
    check("R8 single pulse", pulses - p0, 1);
    check("R8 mode", mode, 2'b00);
    check("R8 pattern", pattern, 4'b1110);
    btn_raw = 1'b0;
    tick(LOCK + 5);

    // R1: reset mid-operation
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick();
    check("R1 mid reset mode", mode, 0);
    check("R1 mid reset pattern", pattern, 4'b1110);
    check("R1 mid reset pulse", mode_updated, 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule